// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that must be serviced inside a time window. A 24-bit down-counter is reloaded from a programmable timer constant when software completes a two-write unlock sequence on the feed register. The counter steps once every four clock cycles. If software stops servicing it, the counter reaches zero and a watchdog event follows. Servicing too early also causes an event. Here "too early" means the counter is still above a programmable window value, or the window is set so low that no service can be valid. Every event latches a timeout flag and pulses an event output. If reset generation is enabled, the event also pulses a reset output. An early-warning flag, which drives the interrupt output, is raised when the counter nears zero.

Software reaches the block through a plain single-cycle register port. There is no back-pressure: a write is taken on the clock edge where `reg_wr` is high, and `reg_rdata` shows the register selected by `reg_addr` within the same cycle. The address map is: 0 mode, 1 timer constant, 2 feed, 3 live count (read only), 4 warning compare, 5 window. Addresses 6 and 7 read as zero. Mode bits are: bit 0 run enable, bit 1 reset-output enable, bit 2 timeout flag, bit 3 warning flag.

Top module: `wwd_timer`

## Requirements
- R1: After reset, mode reads 0, the timer constant reads 0xFF, count reads 0xFF, warning reads 0, window reads 0xFFFFFF, and `warn_irq`, `wdt_event` and `wdt_reset` are low.
- R2: Once armed, the count decreases by exactly one every four clock cycles, so any 40 consecutive cycles without a feed lower it by 10.
- R3: A timer constant write (address 1) stores the 24-bit value, except that any value below 0xFF is stored as 0xFF.
- R4: A feed is valid when a write of low byte 0xAA to address 2 is followed by a write of low byte 0x55 to address 2. A valid feed loads the count from the timer constant at the edge of the 0x55 write. Any other feed write in between aborts the sequence, and a 0x55 with no pending 0xAA does nothing. Writes to other addresses do not disturb the sequence.
- R5: Mode bit 0 can be set but not cleared by a write. The counter holds still until the first valid feed made while bit 0 is set, which arms it.
- R6: A valid feed while armed is an event if the count is above the window (address 5) or the window is below 0x100. The count is still reloaded.
- R7: When armed, a count step that finds the count at zero is an event, and the count reloads from the timer constant.
- R8: Every event sets mode bit 2 and pulses `wdt_event` for one cycle, starting in the cycle where bit 2 first reads 1. If mode bit 1 is set, `wdt_reset` pulses at the same time. Writing mode with bit 2 at 0 clears the flag, and writing it at 1 leaves it alone. A new event takes priority over a clear.
- R9: When armed, a count step that finds the upper 14 count bits at zero and the low 10 bits equal to the warning value (address 4) sets mode bit 3. That is one step after the count reaches the value. With warning value 0, this coincides with the expiry event. `warn_irq` follows bit 3.
- R10: Writing mode with bit 3 at 1 clears the warning flag. A new match in the same cycle takes priority.
- R11: Address 3 returns the live count, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, taken at the clock edge |
| reg_addr | input | 3 | Register select for write and read |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 24 | Selected register, combinational |
| warn_irq | output | 1 | Early-warning interrupt (mode bit 3) |
| wdt_event | output | 1 | One-cycle pulse per watchdog event |
| wdt_reset | output | 1 | One-cycle reset pulse when reset generation is enabled |

## Verification
The assertions assume that `reg_wr`, `reg_addr` and `reg_wdata` are known and stable around each rising edge. They also assume the clock runs freely from reset, so the divide-by-four phase counts from the reset release. The stimulus changes inputs just after each rising edge. It keeps random timer constants and windows small enough that expiries, early feeds and warning matches all happen within the run. It also mixes in aborted and orphaned feed writes and mode writes that try to clear the enable.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  localparam int ADDR_W = 3;
  localparam logic [7:0] FEED_KEY1 = 8'hAA;
  localparam logic [7:0] FEED_KEY2 = 8'h55;

  typedef enum logic [ADDR_W-1:0] {
    A_MODE  = 3'd0,
    A_CONST = 3'd1,
    A_FEED  = 3'd2,
    A_COUNT = 3'd3,
    A_WARN  = 3'd4,
    A_WIN   = 3'd5
  } reg_addr_e;

  // bit 0 is the last field
  typedef struct packed {
    logic wint;
    logic tof;
    logic rsten;
    logic en;
  } mode_t;

  typedef enum logic {F_IDLE = 1'b0, F_KEY1 = 1'b1} feed_st_e;
endpackage

// File: rtl/wwd_prescale.sv
module wwd_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else                    pre_q <= pre_q + 1'b1;
      end

      assign tick = (pre_q == LAST);

      // R2: steps never come on back-to-back cycles
      p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/wwd_feed_unlock.sv
module wwd_feed_unlock
  import wwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       feed_wr,
  input  logic [7:0] feed_byte,
  output logic       feed_ok
);
  feed_st_e st_q;

  assign feed_ok = feed_wr && (st_q == F_KEY1) && (feed_byte == FEED_KEY2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= F_IDLE;
    else if (feed_wr)
      st_q <= (st_q == F_IDLE && feed_byte == FEED_KEY1) ? F_KEY1 : F_IDLE;
  end

  // R4: a completed sequence always leaves the unlock idle
  p_unlock_rearm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    feed_ok |=> (st_q == F_IDLE));
endmodule

// File: rtl/wwd_down_counter.sv
module wwd_down_counter #(
  parameter int CNT_W     = 24,
  parameter int WARN_W    = 10,
  parameter int CONST_MIN = 255,
  parameter int WIN_MIN   = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              feed_ok,
  input  logic              en,
  input  logic [CNT_W-1:0]  cnst,
  input  logic [CNT_W-1:0]  win,
  input  logic [WARN_W-1:0] warn,
  output logic [CNT_W-1:0]  cnt,
  output logic              wd_event,
  output logic              warn_hit
);
  localparam int HI_W = CNT_W - WARN_W;

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             win_low, bad_feed, expire, low_zone;

  assign win_low  = (win < CNT_W'(WIN_MIN));
  assign bad_feed = feed_ok && armed_q && (win_low || (cnt_q > win));
  assign expire   = !feed_ok && tick && armed_q && (cnt_q == '0);
  assign wd_event = bad_feed || expire;
  assign low_zone = (cnt_q[CNT_W-1:WARN_W] == {HI_W{1'b0}});
  assign warn_hit = tick && armed_q && low_zone && (cnt_q[WARN_W-1:0] == warn);
  assign cnt      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_W'(CONST_MIN);
      armed_q <= 1'b0;
    end else begin
      if (feed_ok)              cnt_q <= cnst;
      else if (tick && armed_q) cnt_q <= (cnt_q == '0) ? cnst : cnt_q - 1'b1;
      if (feed_ok && en)        armed_q <= 1'b1;
    end
  end

  // R7: expiry reloads from the constant
  p_expire_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == $past(cnst)));
  // R5: an unarmed counter without a feed stays put
  p_hold_unarmed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !feed_ok) |=> $stable(cnt_q));
  // R6: a window below the floor never allows a clean feed
  p_low_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (feed_ok && armed_q && win_low) |-> wd_event);
endmodule

// File: rtl/wwd_timer.sv
module wwd_timer
  import wwd_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int WARN_W    = 10,
  parameter int PRE_DIV   = 4,
  parameter int CONST_MIN = 255,
  parameter int WIN_MIN   = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              warn_irq,
  output logic              wdt_event,
  output logic              wdt_reset
);
  localparam logic [CNT_W-1:0] CONST_FLOOR = CNT_W'(CONST_MIN);

  mode_t             mode_q;
  logic [CNT_W-1:0]  cnst_q, win_q, cnt;
  logic [WARN_W-1:0] warn_q;
  logic              tick, feed_ok, wd_event, warn_hit;
  logic              evt_q, rst_q;
  logic              wr_mode, wr_const, wr_feed, wr_warn, wr_win;

  assign wr_mode  = reg_wr && (reg_addr == A_MODE);
  assign wr_const = reg_wr && (reg_addr == A_CONST);
  assign wr_feed  = reg_wr && (reg_addr == A_FEED);
  assign wr_warn  = reg_wr && (reg_addr == A_WARN);
  assign wr_win   = reg_wr && (reg_addr == A_WIN);

  wwd_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  wwd_feed_unlock u_feed (
    .clk(clk), .rst_n(rst_n), .feed_wr(wr_feed),
    .feed_byte(reg_wdata[7:0]), .feed_ok(feed_ok)
  );

  wwd_down_counter #(
    .CNT_W(CNT_W), .WARN_W(WARN_W), .CONST_MIN(CONST_MIN), .WIN_MIN(WIN_MIN)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .feed_ok(feed_ok), .en(mode_q.en),
    .cnst(cnst_q), .win(win_q), .warn(warn_q), .cnt(cnt),
    .wd_event(wd_event), .warn_hit(warn_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      cnst_q <= CONST_FLOOR;
      win_q  <= '1;
      warn_q <= '0;
      evt_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      mode_q.en <= mode_q.en | (wr_mode & reg_wdata[0]);
      if (wr_mode) mode_q.rsten <= reg_wdata[1];
      if (wd_event)                     mode_q.tof <= 1'b1;
      else if (wr_mode && !reg_wdata[2]) mode_q.tof <= 1'b0;
      if (warn_hit)                     mode_q.wint <= 1'b1;
      else if (wr_mode && reg_wdata[3])  mode_q.wint <= 1'b0;
      if (wr_const) cnst_q <= (reg_wdata < CONST_FLOOR) ? CONST_FLOOR : reg_wdata;
      if (wr_warn)  warn_q <= reg_wdata[WARN_W-1:0];
      if (wr_win)   win_q  <= reg_wdata;
      evt_q <= wd_event;
      rst_q <= wd_event & mode_q.rsten;
    end
  end

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = CNT_W'(mode_q);
      A_CONST: reg_rdata = cnst_q;
      A_COUNT: reg_rdata = cnt;
      A_WARN:  reg_rdata = CNT_W'(warn_q);
      A_WIN:   reg_rdata = win_q;
      default: reg_rdata = '0;
    endcase
  end

  assign warn_irq  = mode_q.wint;
  assign wdt_event = evt_q;
  assign wdt_reset = rst_q;

  // R5: the run enable is sticky
  p_en_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.en |=> mode_q.en);
  // R8: a reset pulse is always an event pulse
  p_rst_with_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |-> wdt_event);
  // R8: the event pulse shows with the flag set
  p_evt_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_event |-> mode_q.tof);
  // R9: the interrupt follows the warning flag
  p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    warn_hit |=> warn_irq);
endmodule

// File: tb/wwd_timer_bench.sv
module wwd_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [23:0] reg_wdata = '0;
  logic [23:0] reg_rdata;
  logic        warn_irq, wdt_event, wdt_reset;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wwd_timer u_wwd_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .warn_irq(warn_irq),
    .wdt_event(wdt_event), .wdt_reset(wdt_reset)
  );

  // reference model built from the requirements
  int          m_pre;
  logic        m_en, m_rsten, m_tof, m_wint, m_arm, m_key, m_evt, m_rst;
  logic [23:0] m_const, m_win, m_cnt;
  logic [9:0]  m_warn;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre <= 0; m_en <= 0; m_rsten <= 0; m_tof <= 0; m_wint <= 0;
      m_arm <= 0; m_key <= 0; m_evt <= 0; m_rst <= 0;
      m_const <= 24'hFF; m_win <= 24'hFFFFFF; m_cnt <= 24'hFF; m_warn <= 0;
    end else begin : mdl
      logic tk, fok, fw, ev, wh;
      tk  = (m_pre == 3);
      fw  = reg_wr && reg_addr == 3'd2;
      fok = fw && m_key && reg_wdata[7:0] == 8'h55;
      ev  = (fok && m_arm && (m_win < 24'h100 || m_cnt > m_win)) ||
            (!fok && tk && m_arm && m_cnt == 0);
      wh  = tk && m_arm && m_cnt < 24'd1024 && m_cnt[9:0] == m_warn;
      m_pre <= (m_pre + 1) % 4;
      if (fw) m_key <= !m_key && reg_wdata[7:0] == 8'hAA;
      if (fok) m_cnt <= m_const;
      else if (tk && m_arm) m_cnt <= (m_cnt == 0) ? m_const : m_cnt - 24'd1;
      if (fok && m_en) m_arm <= 1;
      if (reg_wr && reg_addr == 3'd0) begin
        if (reg_wdata[0]) m_en <= 1;
        m_rsten <= reg_wdata[1];
        if (!reg_wdata[2] && !ev) m_tof <= 0;
        if (reg_wdata[3] && !wh) m_wint <= 0;
      end
      if (ev) m_tof <= 1;
      if (wh) m_wint <= 1;
      if (reg_wr && reg_addr == 3'd1) m_const <= (reg_wdata < 24'hFF) ? 24'hFF : reg_wdata;
      if (reg_wr && reg_addr == 3'd4) m_warn <= reg_wdata[9:0];
      if (reg_wr && reg_addr == 3'd5) m_win <= reg_wdata;
      m_evt <= ev;
      m_rst <= ev && m_rsten;
    end
  end

  function automatic logic [23:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: exp_rd = {20'd0, m_wint, m_tof, m_rsten, m_en};
      3'd1: exp_rd = m_const;
      3'd3: exp_rd = m_cnt;
      3'd4: exp_rd = {14'd0, m_warn};
      3'd5: exp_rd = m_win;
      default: exp_rd = 24'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: tag_of = "R5 R8 R10";
      3'd1: tag_of = "R3";
      3'd3: tag_of = "R2 R4 R7 R11";
      3'd4: tag_of = "R9";
      3'd5: tag_of = "R6";
      default: tag_of = "R1";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk(tag_of(reg_addr), reg_rdata, exp_rd(reg_addr));
      chk("R9 R10 irq", {23'd0, warn_irq}, {23'd0, m_wint});
      chk("R6 R7 event", {23'd0, wdt_event}, {23'd0, m_evt});
      chk("R8 reset", {23'd0, wdt_reset}, {23'd0, m_rst});
    end
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [23:0] exp);
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
    @(posedge clk); #1;
  endtask

  task automatic feed();
    wr(3'd2, 24'hAA);
    wr(3'd2, 24'h55);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    idle(3);
    rst_n = 1;
    idle(2);
    // R1 reset values
    rd_chk("R1 mode", 3'd0, 24'h0);
    rd_chk("R1 const", 3'd1, 24'hFF);
    rd_chk("R1 count", 3'd3, 24'hFF);
    rd_chk("R1 window", 3'd5, 24'hFFFFFF);
    rd_chk("R1 warn", 3'd4, 24'h0);
    // R3 clamp
    wr(3'd1, 24'h10);
    rd_chk("R3 clamp", 3'd1, 24'hFF);
    wr(3'd1, 24'h300);
    rd_chk("R3 store", 3'd1, 24'h300);
    // R5 sticky enable
    wr(3'd0, 24'h1);
    wr(3'd0, 24'h0);
    rd_chk("R5 sticky", 3'd0, 24'h1);
    idle(20);
    rd_chk("R5 unarmed hold", 3'd3, 24'hFF);
    // R4 orphan and aborted feeds
    wr(3'd2, 24'h55);
    rd_chk("R4 orphan", 3'd3, 24'hFF);
    wr(3'd2, 24'hAA); wr(3'd2, 24'h12); wr(3'd2, 24'h55);
    rd_chk("R4 abort", 3'd3, 24'hFF);
    // R11 count is read only
    wr(3'd3, 24'h777);
    rd_chk("R11 ro", 3'd3, 24'hFF);
    // valid feed, other address between keys
    wr(3'd2, 24'hAA); wr(3'd4, 24'h0); wr(3'd2, 24'h55);
    reg_addr = 3'd3;
    @(negedge clk); chk("R4 reload", reg_rdata, 24'h300);
    repeat (40) @(negedge clk);
    chk("R2 rate", reg_rdata, 24'h2F6);
    @(posedge clk); #1;
    // R6 early feed
    wr(3'd5, 24'h200);
    feed();
    rd_chk("R6 early", 3'd0, 24'h5);
    wr(3'd0, 24'h0);
    rd_chk("R8 clear", 3'd0, 24'h1);
    // R6 low window makes any feed an event
    wr(3'd1, 24'hFF);
    wr(3'd5, 24'hF0);
    feed();
    wr(3'd0, 24'h0);
    idle(90);
    feed();
    rd_chk("R6 low window", 3'd0, 24'h5);
    // R9 warning then R7 expiry with reset
    wr(3'd5, 24'hFFFFFF);
    wr(3'd4, 24'h20);
    wr(3'd0, 24'h3);
    feed();
    idle(4 * (24'hFF - 24'h20) - 12);
    reg_addr = 3'd0;
    @(negedge clk); chk("R9 not yet", {23'd0, warn_irq}, 24'd0);
    repeat (16) @(negedge clk);
    chk("R9 raised", {23'd0, warn_irq}, 24'd1);
    @(posedge clk); #1;
    wr(3'd0, 24'hB);
    @(negedge clk); chk("R10 clear", {23'd0, warn_irq}, 24'd0);
    begin : wait_rst
      bit seen = 0;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        if (wdt_reset) seen = 1;
      end
      chk("R7 R8 expiry reset", {23'd0, seen}, 24'd1);
    end
    @(posedge clk); #1;
    // random phase, checked against the model every cycle
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom % 9;
      case (op)
        0, 1, 2: feed();
        3: wr(3'd2, 24'($urandom % 256));
        4: wr(3'd0, 24'($urandom % 16));
        5: wr(3'd1, 24'($urandom % 24'h200));
        6: wr(3'd4, 24'($urandom % 24'h180));
        7: wr(3'd5, ($urandom % 2) ? 24'hFFFFFF : 24'($urandom % 24'h200));
        default: wr(3'($urandom % 8), 24'($urandom));
      endcase
      reg_addr = 3'($urandom % 8);
      idle(($urandom % 16 == 0) ? 1200 : int'($urandom % 30));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule